// File: doc/BRIEF.md
# Single-Wire Debug Sync Detector

This block sits on the target side of an open-drain, single-wire debug line. It recognises a synchronisation request from the host. The request has no command code. It is a low level held far longer than any low that a normal serial bit produces. The block counts consecutive low samples of the line. Once the count reaches the request threshold it raises a one-cycle detection strobe. It then waits for the host to let the line return high; a single high sample is enough, so the host's short actively driven rising edge is accepted.

After the line is high, the block waits a fixed number of debug clock cycles. It then pulls the line low for a fixed number of debug clock cycles and ends with a one-cycle speed-up enable, which drives the line high to sharpen the rising edge. The host times this low pulse to learn the target's debug clock rate. The block never drives the line high outside that single cycle. While a response is in progress, line activity is ignored.

The line input is passed through a small synchroniser before any decision is made. All timing below counts debug clock edges. S stands for the synchroniser depth (default 2). The default request threshold, turnaround wait and response length are 128, 16 and 128 cycles.

Top module: `sdsync_detector`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `drive_low_o`, `speedup_o`, `sync_det_o` and `busy_o` are all 0.
- R2: Let `line_i` be sampled low at REQ consecutive edges (default 128), the first of them edge f, while the block is idle. Then `sync_det_o` is 1 for exactly one cycle, the cycle following edge f+S+REQ-1.
- R3: A low run shorter than REQ samples produces no strobe and leaves `busy_o` at 0. A single high sample restarts the count, so two runs of REQ-1 lows separated by one high are not a request.
- R4: After detection, `drive_low_o` stays 0 for as long as the line stays low, however long that is.
- R5: Let h be the first edge at which `line_i` is sampled high after a detected request. `drive_low_o` rises in the cycle following edge h+S+WAIT (WAIT default 16). This holds even when the line is high for only that one sample.
- R6: `drive_low_o` stays 1 for exactly RESP consecutive cycles (default 128) per response.
- R7: `speedup_o` is 1 for exactly one cycle, the cycle right after the last `drive_low_o` cycle. It is never 1 together with `drive_low_o`.
- R8: `busy_o` rises in the strobe cycle and falls in the cycle after the `speedup_o` cycle. `drive_low_o` or `speedup_o` is never 1 without `busy_o`.
- R9: A low lasting several times REQ produces exactly one strobe and one response.
- R10: Low samples taken while a response is in progress are not counted. If the line stays low through the end of a response, the next strobe comes REQ cycles after the first cycle in which `busy_o` is 0 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Debug clock |
| rst_ni | input | 1 | Asynchronous active-low reset; release is already synchronous to `clk_i` |
| line_i | input | 1 | Sampled level of the debug line (1 = high) |
| drive_low_o | output | 1 | Enable for the open-drain pull-down of the debug line |
| speedup_o | output | 1 | One-cycle enable to drive the line high at the end of the response |
| sync_det_o | output | 1 | One-cycle strobe when a synchronisation request is recognised |
| busy_o | output | 1 | Detection, turnaround or response in progress |

## Verification
Some properties are checked by assertions on every cycle:
- the strobe lasts a single cycle and only starts a busy period;
- the low counter never exceeds its threshold, and a high sample blocks detection in the next cycle;
- every pull-down run is exactly the response length;
- the speed-up enable follows the pull-down for one cycle, and both sit inside busy.

Other properties need the bench's scenarios. These are the exact latencies from the first low sample to the strobe and from the first high sample to the pull-down, the rejection of lows just under the threshold or broken by one high sample, the single response for a very long low, and the recount of a low that overlaps a response.

// File: rtl/sdsync_pkg.sv
package sdsync_pkg;

  typedef enum logic [2:0] {
    SD_IDLE      = 3'd0,
    SD_WAIT_HIGH = 3'd1,
    SD_DELAY     = 3'd2,
    SD_RESPOND   = 3'd3,
    SD_SPEEDUP   = 3'd4
  } sd_state_e;

  // Bits needed to hold the values 0 .. n-1, at least one bit.
  function automatic int unsigned sd_cw(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/sdsync_line_sync.sv
module sdsync_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);

  if (STAGES == 0) begin : g_bypass
    assign line_o = line_i;
  end else begin : g_chain
    logic [STAGES-1:0] stage_q;
    logic [STAGES-1:0] stage_d;

    always_comb begin
      stage_d[0] = line_i;
      for (int i = 1; i < STAGES; i++) begin
        stage_d[i] = stage_q[i-1];
      end
    end

    // Idle line level is high, so reset to 1.
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q <= '1;
      end else begin
        stage_q <= stage_d;
      end
    end

    assign line_o = stage_q[STAGES-1];
  end

endmodule

// File: rtl/sdsync_low_timer.sv
module sdsync_low_timer
  import sdsync_pkg::*;
#(
  parameter int unsigned THRESH = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic line_i,
  output logic reached_o
);

  localparam int unsigned CW = sd_cw(THRESH + 1);
  localparam logic [CW-1:0] LIMIT = CW'(THRESH);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  // Count only low samples while armed; stop at the limit.
  assign cnt_en = arm_i && !line_i && (cnt_q != LIMIT);

  always_comb begin
    cnt_d = cnt_q;
    if (!arm_i || line_i) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign reached_o = (cnt_q == LIMIT);

  a_r9_counter_saturates: assert property (
    @(posedge clk_i) disable iff (!rst_ni) cnt_q <= LIMIT);

  a_r3_high_blocks_detect: assert property (
    @(posedge clk_i) disable iff (!rst_ni) line_i |=> !reached_o);

endmodule

// File: rtl/sdsync_pulse_timer.sv
module sdsync_pulse_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          dec_en;

  assign dec_en = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (dec_en) begin
      cnt_d = cnt_q - TW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdsync_ctrl.sv
module sdsync_ctrl
  import sdsync_pkg::*;
#(
  parameter int unsigned WAIT_CYCLES = 16,
  parameter int unsigned RESP_CYCLES = 128,
  parameter int unsigned TW          = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reached_i,
  input  logic          line_high_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          arm_o,
  output logic          drive_low_o,
  output logic          speedup_o,
  output logic          det_o,
  output logic          busy_o
);

  localparam logic [TW-1:0] WAIT_V = TW'(WAIT_CYCLES - 1);
  localparam logic [TW-1:0] RESP_V = TW'(RESP_CYCLES - 1);

  sd_state_e state_q;
  sd_state_e state_d;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    det_o      = 1'b0;
    unique case (state_q)
      SD_IDLE: begin
        if (reached_i) begin
          det_o = 1'b1;
          if (line_high_i) begin
            // Line already released: start the turnaround at once.
            state_d    = SD_DELAY;
            tmr_load_o = 1'b1;
            tmr_val_o  = WAIT_V;
          end else begin
            state_d = SD_WAIT_HIGH;
          end
        end
      end
      SD_WAIT_HIGH: begin
        if (line_high_i) begin
          state_d    = SD_DELAY;
          tmr_load_o = 1'b1;
          tmr_val_o  = WAIT_V;
        end
      end
      SD_DELAY: begin
        if (tmr_zero_i) begin
          state_d    = SD_RESPOND;
          tmr_load_o = 1'b1;
          tmr_val_o  = RESP_V;
        end
      end
      SD_RESPOND: begin
        if (tmr_zero_i) begin
          state_d = SD_SPEEDUP;
        end
      end
      SD_SPEEDUP: begin
        state_d = SD_IDLE;
      end
      default: begin
        state_d = SD_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SD_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign arm_o       = (state_q == SD_IDLE) || (state_q == SD_WAIT_HIGH);
  assign drive_low_o = (state_q == SD_RESPOND);
  assign speedup_o   = (state_q == SD_SPEEDUP);
  assign busy_o      = (state_q != SD_IDLE) || det_o;

  a_r2_strobe_single: assert property (
    @(posedge clk_i) disable iff (!rst_ni) det_o |=> !det_o);

  a_r10_strobe_starts_busy: assert property (
    @(posedge clk_i) disable iff (!rst_ni) det_o |-> $rose(busy_o));

  a_r7_speedup_after_drive: assert property (
    @(posedge clk_i) disable iff (!rst_ni) $rose(speedup_o) |-> $past(drive_low_o));

  a_r7_speedup_one_cycle: assert property (
    @(posedge clk_i) disable iff (!rst_ni) speedup_o |=> (!speedup_o && !drive_low_o));

  a_r8_drive_inside_busy: assert property (
    @(posedge clk_i) disable iff (!rst_ni) (drive_low_o || speedup_o) |-> busy_o);

endmodule

// File: rtl/sdsync_detector.sv
module sdsync_detector
  import sdsync_pkg::*;
#(
  parameter int unsigned SYNC_STAGES      = 2,
  parameter int unsigned REQ_LOW_CYCLES   = 128,
  parameter int unsigned RESP_WAIT_CYCLES = 16,
  parameter int unsigned RESP_LOW_CYCLES  = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic drive_low_o,
  output logic speedup_o,
  output logic sync_det_o,
  output logic busy_o
);

  localparam int unsigned TMAX = (RESP_WAIT_CYCLES > RESP_LOW_CYCLES) ?
                                 RESP_WAIT_CYCLES : RESP_LOW_CYCLES;
  localparam int unsigned TW   = sd_cw(TMAX);

  logic          line_s;
  logic          arm;
  logic          reached;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;

  sdsync_line_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .line_o (line_s)
  );

  sdsync_low_timer #(
    .THRESH (REQ_LOW_CYCLES)
  ) u_low (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (arm),
    .line_i    (line_s),
    .reached_o (reached)
  );

  sdsync_pulse_timer #(
    .TW (TW)
  ) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  sdsync_ctrl #(
    .WAIT_CYCLES (RESP_WAIT_CYCLES),
    .RESP_CYCLES (RESP_LOW_CYCLES),
    .TW          (TW)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reached_i   (reached),
    .line_high_i (line_s),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .arm_o       (arm),
    .drive_low_o (drive_low_o),
    .speedup_o   (speedup_o),
    .det_o       (sync_det_o),
    .busy_o      (busy_o)
  );

  // Run-length monitor for the pull-down, used only by the checks below.
  localparam int unsigned RCW = sd_cw(RESP_LOW_CYCLES + 2);
  localparam logic [RCW-1:0] RUN_MAX  = '1;
  localparam logic [RCW-1:0] RESP_CNT = RCW'(RESP_LOW_CYCLES);

  logic [RCW-1:0] drv_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_run_q <= '0;
    end else if (!drive_low_o) begin
      drv_run_q <= '0;
    end else if (drv_run_q != RUN_MAX) begin
      drv_run_q <= drv_run_q + RCW'(1);
    end
  end

  a_r6_drive_not_too_long: assert property (
    @(posedge clk_i) disable iff (!rst_ni) drive_low_o |-> (drv_run_q < RESP_CNT));

  a_r6_drive_exact_length: assert property (
    @(posedge clk_i) disable iff (!rst_ni) $fell(drive_low_o) |-> (drv_run_q == RESP_CNT));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_quiet_in_reset: assert (!drive_low_o && !speedup_o && !sync_det_o && !busy_o);
    end
  end

endmodule

// File: tb/sdsync_detector_tb_top.sv
`timescale 1ns/1ps
module sdsync_detector_tb_top;

  localparam int S     = 2;
  localparam int REQ   = 128;
  localparam int WAITC = 16;
  localparam int RESP  = 128;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic host_low;
  logic line_w;
  logic drive_low, speedup, sync_det, busy;

  // Open-drain line: low if either side pulls it down.
  assign line_w = ~(host_low | drive_low);

  sdsync_detector #(
    .SYNC_STAGES      (S),
    .REQ_LOW_CYCLES   (REQ),
    .RESP_WAIT_CYCLES (WAITC),
    .RESP_LOW_CYCLES  (RESP)
  ) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .line_i      (line_w),
    .drive_low_o (drive_low),
    .speedup_o   (speedup),
    .sync_det_o  (sync_det),
    .busy_o      (busy)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int det_at[8];
  int rise_at[4];
  int fall_at[4];
  int spd_at[4];
  int brise_at[4];
  int bfall_at[4];
  int det_n, rise_n, fall_n, spd_n, brise_n, bfall_n, overlap_n;
  bit drv_prev, busy_prev;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic clear_mon();
    det_n = 0; rise_n = 0; fall_n = 0; spd_n = 0; brise_n = 0; bfall_n = 0;
    overlap_n = 0;
    for (int i = 0; i < 8; i++) det_at[i] = -1;
    for (int i = 0; i < 4; i++) begin
      rise_at[i] = -1; fall_at[i] = -1; spd_at[i] = -1;
      brise_at[i] = -1; bfall_at[i] = -1;
    end
  endtask

  // One clock: wait for the falling edge, then record the outputs.
  task automatic step();
    @(negedge clk);
    if (sync_det) begin
      if (det_n < 8) det_at[det_n] = cyc;
      det_n++;
    end
    if (drive_low && !drv_prev) begin
      if (rise_n < 4) rise_at[rise_n] = cyc;
      rise_n++;
    end
    if (!drive_low && drv_prev) begin
      if (fall_n < 4) fall_at[fall_n] = cyc;
      fall_n++;
    end
    if (speedup) begin
      if (spd_n < 4) spd_at[spd_n] = cyc;
      spd_n++;
    end
    if (speedup && drive_low) overlap_n++;
    if (busy && !busy_prev) begin
      if (brise_n < 4) brise_at[brise_n] = cyc;
      brise_n++;
    end
    if (!busy && busy_prev) begin
      if (bfall_n < 4) bfall_at[bfall_n] = cyc;
      bfall_n++;
    end
    drv_prev  = drive_low;
    busy_prev = busy;
  endtask

  task automatic idle(input int n);
    host_low = 1'b0;
    repeat (n) step();
  endtask

  task automatic expect_response(input int f, input int h);
    chk_eq("R2 strobe count", det_n, 1);
    chk_eq("R2 strobe cycle", det_at[0], f + S + REQ - 1);
    chk_eq("R5 drive start", rise_at[0], h + S + WAITC);
    chk_eq("R6 drive length", fall_at[0] - rise_at[0], RESP);
    chk_eq("R7 speedup count", spd_n, 1);
    chk_eq("R7 speedup cycle", spd_at[0], fall_at[0]);
    chk_eq("R7 overlap", overlap_n, 0);
    chk_eq("R8 busy rise", brise_at[0], det_at[0]);
    chk_eq("R8 busy fall", bfall_at[0], spd_at[0] + 1);
  endtask

  task automatic run_low(input int len, input bit expect_det);
    int f, h;
    idle(6);
    clear_mon();
    host_low = 1'b1;
    f = cyc + 1;
    repeat (len) step();
    if (len >= REQ) chk_eq("R4 no drive while low", rise_n, 0);
    host_low = 1'b0;
    h = cyc + 1;
    repeat (S + WAITC + RESP + 20) step();
    if (expect_det) begin
      expect_response(f, h);
    end else begin
      chk_eq("R3 no strobe", det_n, 0);
      chk_eq("R3 no busy", brise_n, 0);
      chk_eq("R3 no drive", rise_n, 0);
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int f, h, guard;
    rst_n     = 1'b0;
    host_low  = 1'b0;
    drv_prev  = 1'b0;
    busy_prev = 1'b0;
    clear_mon();

    // R1: reset state
    repeat (3) @(negedge clk);
    chk_eq("R1 drive in reset", int'(drive_low), 0);
    chk_eq("R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    step();
    chk_eq("R1 drive", int'(drive_low), 0);
    chk_eq("R1 speedup", int'(speedup), 0);
    chk_eq("R1 strobe", int'(sync_det), 0);
    chk_eq("R1 busy", int'(busy), 0);

    // R3: lows just under the threshold
    for (int len = 1; len < REQ; len = (len == 1) ? REQ - 3 : len + 1) begin
      run_low(len, 1'b0);
    end

    // R3: one high sample restarts the count
    idle(6);
    clear_mon();
    host_low = 1'b1;
    repeat (REQ - 1) step();
    host_low = 1'b0;
    step();
    host_low = 1'b1;
    repeat (REQ - 1) step();
    host_low = 1'b0;
    repeat (40) step();
    chk_eq("R3 broken low strobe", det_n, 0);
    chk_eq("R3 broken low busy", brise_n, 0);

    // R2 R4 R5 R6 R7 R8: lows at and above the threshold
    run_low(REQ, 1'b1);
    run_low(REQ + 1, 1'b1);
    run_low(REQ + 7, 1'b1);

    // R9: very long low gives one response
    run_low(4 * REQ, 1'b1);
    chk_eq("R9 single strobe", det_n, 1);
    chk_eq("R9 single response", rise_n, 1);

    // R5: a one-sample high ends the wait
    idle(6);
    clear_mon();
    host_low = 1'b1;
    repeat (200) step();
    host_low = 1'b0;
    h = cyc + 1;
    step();
    host_low = 1'b1;
    repeat (40) step();
    host_low = 1'b0;
    repeat (S + WAITC + RESP + 20) step();
    chk_eq("R5 brief high drive start", rise_at[0], h + S + WAITC);
    chk_eq("R10 no strobe during turnaround", det_n, 1);

    // R10: low overlapping a response is recounted after it
    idle(6);
    clear_mon();
    host_low = 1'b1;
    f = cyc + 1;
    repeat (REQ + 3) step();
    host_low = 1'b0;
    h = cyc + 1;
    repeat (4) step();
    host_low = 1'b1;
    guard = 0;
    while (det_n < 2 && guard < 800) begin
      step();
      guard++;
    end
    host_low = 1'b0;
    chk_eq("R10 first drive start", rise_at[0], h + S + WAITC);
    chk_eq("R10 strobes seen", det_n, 2);
    chk_eq("R10 recount after busy", det_at[1], bfall_at[0] + REQ);
    repeat (S + WAITC + RESP + 20) step();
    chk_eq("R10 second response", rise_n, 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule